// File: doc/BRIEF.md
# Gated Frequency Counter Core

This block measures the rate of a pulse train by counting its rising edges over a fixed gate window. The pulse input is expected to come from an external divide-by-ten prescaler. The gate is sized to one tenth of a second of system clock, so each count is one hundred hertz of the original signal. The pulse input is asynchronous to the system clock. It passes through a two-stage synchroniser, and each low-to-high transition is detected on the clock.

The count is kept as a chain of BCD digits. The chain is cleared when the gate opens. While the gate is open, an active-low busy line is driven low. When the gate closes, the count is copied into an output register. That register holds its value until the next gate closes. The least significant digit is not brought out, so the display reads in kilohertz of the original signal. A sticky overflow flag marks a count that ran past the top digit. A short idle interval, with busy high, separates one gate from the next.

Top module: `gated_freq_counter`

## Requirements
- R1: While reset is low, and in the first cycle after it, busy_n is 1, result_bcd is 0 and overflow is 0.
- R2: Each gate lasts exactly GATE_CYCLES clock cycles, and busy_n is 0 throughout it.
- R3: Between two gates, busy_n stays 1 for exactly IDLE_CYCLES clock cycles.
- R4: pulse_in is synchronised with two flops. Each low-to-high transition that is held at least one clock cycle high and one clock cycle low is counted exactly once.
- R5: The count is cleared when each gate opens, so every result reflects only the edges of its own gate.
- R6: Edges of pulse_in that fall in the idle interval have no effect on the result.
- R7: result_bcd and overflow are loaded one clock cycle after busy_n rises, and they hold until the next gate closes.
- R8: The lowest counted digit is dropped. result_bcd[3:0] is the tens digit of the count, and each further nibble holds the next higher digit. This gives floor(N/10) mod 10^(DIGITS-1) in BCD.
- R9: overflow is 1 exactly when the gate counted 10^DIGITS edges or more. It is loaded together with the result.
- R10: Every counted digit stays in 0..9 and wraps from 9 to 0 with a carry into the next digit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pulse_in | input | 1 | Prescaled pulse input, asynchronous |
| busy_n | output | 1 | Low while the gate is open |
| result_bcd | output | (DIGITS-1)*4 | Latched BCD result without the lowest digit |
| overflow | output | 1 | Latched count overflow |

## Verification
A rise on pulse_in is counted at the third rising clock edge after it. Two of those edges are the synchroniser stages and the third is the counter. The bench therefore starts pulses three cycles after busy_n falls, and it ends them well before the gate closes. This makes the expected count exactly the number of pulses sent. The result is due one clock after busy_n rises. The bench checks the previous result on the falling edge where it first sees busy_n high, and the new result on the next falling edge. It also counts gate and idle lengths in whole clock cycles on falling edges.

// File: rtl/fcnt_pkg.sv
package fcnt_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_GATE = 1'b1
  } gate_st_e;

  localparam int BCD_W = 4;
endpackage

// File: rtl/fcnt_edge_sync.sv
module fcnt_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_a,
  output logic rise_o
);
  // stage0/stage1 synchronise, stage2 holds the previous synchronised value
  logic [2:0] sh_q;
  logic [2:0] sh_d;

  always_comb begin
    sh_d = {sh_q[1:0], sig_a};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rise_o = sh_q[1] & ~sh_q[2];

  // R4
  rise_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/fcnt_gate_timer.sv
module fcnt_gate_timer #(
  parameter int GATE_CYCLES = 10_000_000,
  parameter int IDLE_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  output logic gate_o,
  output logic open_o,
  output logic close_o
);
  import fcnt_pkg::*;

  localparam int MAXC = (GATE_CYCLES > IDLE_CYCLES) ? GATE_CYCLES : IDLE_CYCLES;
  localparam int TW   = (MAXC > 2) ? $clog2(MAXC) : 1;
  localparam logic [TW-1:0] GATE_LAST = TW'(GATE_CYCLES - 1);
  localparam logic [TW-1:0] IDLE_LAST = TW'(IDLE_CYCLES - 1);

  gate_st_e        state_q, state_d;
  logic [TW-1:0]   tmr_q, tmr_d;

  always_comb begin
    state_d = state_q;
    tmr_d   = tmr_q + 1'b1;
    open_o  = 1'b0;
    close_o = 1'b0;
    case (state_q)
      ST_IDLE: if (tmr_q == IDLE_LAST) begin
        state_d = ST_GATE;
        tmr_d   = '0;
        open_o  = 1'b1;
      end
      ST_GATE: if (tmr_q == GATE_LAST) begin
        state_d = ST_IDLE;
        tmr_d   = '0;
        close_o = 1'b1;
      end
      default: begin
        state_d = ST_IDLE;
        tmr_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tmr_q   <= '0;
    end else begin
      state_q <= state_d;
      tmr_q   <= tmr_d;
    end
  end

  assign gate_o = (state_q == ST_GATE);

  // R2
  gate_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gate_o) |-> ($past(tmr_q) == GATE_LAST));
  // R3
  idle_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_o) |-> ($past(tmr_q) == IDLE_LAST));
endmodule

// File: rtl/fcnt_bcd_digit.sv
module fcnt_bcd_digit (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       cin,
  output logic [3:0] q,
  output logic       cout
);
  logic [3:0] q_d;

  always_comb begin
    q_d = q;
    if (clr)          q_d = 4'd0;
    else if (cin)     q_d = (q == 4'd9) ? 4'd0 : q + 4'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 4'd0;
    else        q <= q_d;
  end

  assign cout = cin & (q == 4'd9);

  // R10
  digit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q <= 4'd9);
  // R10
  digit_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cin && !clr && q == 4'd9) |=> (q == 4'd0));
endmodule

// File: rtl/fcnt_bcd_chain.sv
module fcnt_bcd_chain #(
  parameter int DIGITS = 7
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           clr,
  input  logic                           inc,
  output logic [DIGITS*fcnt_pkg::BCD_W-1:0] count_o,
  output logic                           ovf_o
);
  import fcnt_pkg::*;

  logic [DIGITS:0] carry;
  logic            ovf_d;

  assign carry[0] = inc;

  for (genvar g = 0; g < DIGITS; g++) begin : g_dig
    fcnt_bcd_digit u_dig (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (clr),
      .cin  (carry[g]),
      .q    (count_o[g*BCD_W +: BCD_W]),
      .cout (carry[g+1])
    );
  end

  always_comb begin
    ovf_d = ovf_o;
    if (clr)                ovf_d = 1'b0;
    else if (carry[DIGITS]) ovf_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovf_o <= 1'b0;
    else        ovf_o <= ovf_d;
  end

  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_o && !clr) |=> ovf_o);
endmodule

// File: rtl/gated_freq_counter.sv
module gated_freq_counter #(
  parameter int GATE_CYCLES = 10_000_000,
  parameter int IDLE_CYCLES = 1000,
  parameter int DIGITS      = 7
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          pulse_in,
  output logic                          busy_n,
  output logic [(DIGITS-1)*4-1:0]       result_bcd,
  output logic                          overflow
);
  import fcnt_pkg::*;

  localparam int CNT_W  = DIGITS * BCD_W;
  localparam int DISP_W = (DIGITS - 1) * BCD_W;

  logic              rise, gate, open_p, close_p, inc;
  logic [CNT_W-1:0]  count;
  logic              cnt_ovf;
  logic              close_q;
  logic [DISP_W-1:0] result_d;
  logic              ovf_d;

  fcnt_edge_sync u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .sig_a (pulse_in),
    .rise_o(rise)
  );

  fcnt_gate_timer #(
    .GATE_CYCLES(GATE_CYCLES),
    .IDLE_CYCLES(IDLE_CYCLES)
  ) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .gate_o (gate),
    .open_o (open_p),
    .close_o(close_p)
  );

  assign inc = rise & gate;

  fcnt_bcd_chain #(.DIGITS(DIGITS)) u_chain (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (open_p),
    .inc    (inc),
    .count_o(count),
    .ovf_o  (cnt_ovf)
  );

  always_comb begin
    result_d = result_bcd;
    ovf_d    = overflow;
    if (close_q) begin
      result_d = count[CNT_W-1:BCD_W];
      ovf_d    = cnt_ovf;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      close_q    <= 1'b0;
      result_bcd <= '0;
      overflow   <= 1'b0;
    end else begin
      close_q    <= close_p;
      result_bcd <= result_d;
      overflow   <= ovf_d;
    end
  end

  assign busy_n = ~gate;

  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(close_q) |-> ($stable(result_bcd) && $stable(overflow)));
  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_n && !open_p) |=> $stable(count));
  // R5
  open_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    open_p |=> (count == '0 && !cnt_ovf));
endmodule

// File: tb/sim_gated_freq_counter.sv
`timescale 1ns/1ps
module sim_gated_freq_counter;
  localparam int GATE = 2400;
  localparam int IDLE = 32;
  localparam int DIG  = 3;
  localparam int DW   = (DIG - 1) * 4;
  localparam int NV   = 8;

  // pulses, period, idle-pulse flag, expected BCD (hundreds:tens), overflow
  localparam int V_N   [NV] = '{0, 7, 10, 123, 999, 1000, 1005, 58};
  localparam int V_P   [NV] = '{2, 3, 2, 5, 2, 2, 2, 4};
  localparam int V_IP  [NV] = '{0, 1, 0, 1, 0, 1, 0, 1};
  localparam int V_EXP [NV] = '{'h00, 'h00, 'h01, 'h12, 'h99, 'h00, 'h00, 'h05};
  localparam int V_OVF [NV] = '{0, 0, 0, 0, 0, 1, 1, 0};

  logic          clk = 1'b0;
  logic          rst_n;
  logic          pulse_in;
  logic          busy_n;
  logic [DW-1:0] result_bcd;
  logic          overflow;

  int checks = 0;
  int fails = 0;
  int idle_seen = 0;
  bit idle_known = 1'b0;
  int prev_exp = 0;
  int prev_ovf = 0;

  always #4 clk = ~clk;

  gated_freq_counter #(
    .GATE_CYCLES(GATE),
    .IDLE_CYCLES(IDLE),
    .DIGITS     (DIG)
  ) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .pulse_in  (pulse_in),
    .busy_n    (busy_n),
    .result_bcd(result_bcd),
    .overflow  (overflow)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  task automatic run(input int n, input int p, input int ip, input int exp, input int ovf);
    int gl;
    forever begin
      @(negedge clk);
      if (!busy_n) break;
      idle_seen++;
      pulse_in = (ip != 0 && idle_seen >= 3 && idle_seen <= 12 && (idle_seen % 2) == 1);
    end
    pulse_in = 1'b0;
    if (idle_known) chk("R3 idle length", idle_seen, IDLE);
    gl = 1;
    forever begin
      @(negedge clk);
      if (busy_n) break;
      gl++;
      pulse_in = (gl >= 3 && ((gl - 3) % p) == 0 && ((gl - 3) / p) < n);
    end
    pulse_in = 1'b0;
    chk("R2 gate length", gl, GATE);
    chk("R7 result held before load", int'(result_bcd), prev_exp);
    chk("R7 overflow held before load", int'(overflow), prev_ovf);
    @(negedge clk);
    chk("R8 R4 R5 R6 R10 result", int'(result_bcd), exp);
    chk("R9 overflow", int'(overflow), ovf);
    prev_exp   = exp;
    prev_ovf   = ovf;
    idle_seen  = 2;
    idle_known = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R2 actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    rst_n    = 1'b0;
    pulse_in = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 busy_n in reset", int'(busy_n), 1);
    chk("R1 result in reset", int'(result_bcd), 0);
    chk("R1 overflow in reset", int'(overflow), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy_n after reset", int'(busy_n), 1);
    idle_seen = 1;

    for (int v = 0; v < NV; v++) begin
      run(V_N[v], V_P[v], V_IP[v], V_EXP[v], V_OVF[v]);
    end

    // directed: reset in the middle of a gate
    while (busy_n) @(negedge clk);
    repeat (100) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 busy_n after mid-gate reset", int'(busy_n), 1);
    chk("R1 result after mid-gate reset", int'(result_bcd), 0);
    chk("R1 overflow after mid-gate reset", int'(overflow), 0);

    summary();
    $finish;
  end
endmodule